// File: doc/BRIEF.md
# Displaced-Reference Shoot-Through Modulator

This block is a carrier-based gate-pulse generator for a three-leg bridge fed from an impedance network that needs shoot-through to boost its voltage. Each leg's upper and lower switches are driven from two separate references. One reference is raised above the phase reference by half of a signed displacement, and the other is lowered by the same amount. Both are compared against a shared triangular carrier. The upper gate is on while its raised reference is above the carrier. The lower gate is on while its lowered reference is below the carrier. A positive displacement therefore makes the two gates of a leg overlap around every normal commutation. This acts as a negative dead time. The overlap produces shoot-through in one leg at a time, twice per leg and six times per carrier period.

The displacement is independent of the phase references, so the shoot-through share and the modulation depth can be set separately. The block also exports its carrier count for neighbouring modulators. It raises a per-leg overlap flag and reports how many overlap events the previous carrier period held.

Top module: `displaced_st_modulator`

## Requirements
- R1: While reset is held, the carrier reads 0, all six gates and three overlap flags are 0, and the event count is 0.
- R2: The carrier counts 0,1,...,CAR_MAX,CAR_MAX-1,...,1 and repeats, changing by exactly one each clock, so one period is 2*CAR_MAX cycles. The valley cycle is the cycle where the carrier reads 0.
- R3: A leg's upper gate (bit 0 = leg u, bit 1 = leg v, bit 2 = leg w) is 1 exactly when that leg's raised reference is strictly greater than the carrier.
- R4: A leg's lower gate (same bit order) is 1 exactly when that leg's lowered reference is strictly smaller than the carrier.
- R5: The half displacement is the displacement shifted right by one with sign kept, so it is rounded toward minus infinity. A phase reference above CAR_MAX is taken as CAR_MAX. The raised reference is the phase reference plus the half displacement, and the lowered reference is the phase reference minus it. Both are clamped to the range 0..CAR_MAX.
- R6: A leg's overlap flag is 1 exactly in the cycles where both of that leg's gates are 1.
- R7: Phase references and displacement are captured only at the clock edge that ends a valley cycle. Input changes at any other time have no effect on the outputs until the next valley.
- R8: From the cycle after a valley, the event count shows the number of overlap-flag rising edges, summed over the three legs, during the period that ended at that valley.
- R9: With a displacement of at least 2 and references whose windows fit inside the carrier range, each leg overlaps twice per period, giving an event count of 6. Each overlap lasts hi-lo-1 cycles. A displacement of 1 gives no overlap.
- R10: A displacement of zero or below never produces an overlap flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_u | input | CAR_W | Phase reference, leg u |
| ref_v | input | CAR_W | Phase reference, leg v |
| ref_w | input | CAR_W | Phase reference, leg w |
| disp | input | DISP_W | Signed displacement between raised and lowered references |
| carrier | output | CAR_W | Triangular carrier count |
| gate_hi | output | 3 | Upper-switch gates, bit 0 = u |
| gate_lo | output | 3 | Lower-switch gates, bit 0 = u |
| overlap | output | 3 | Per-leg shoot-through flags |
| event_count | output | 3 | Overlap events in the last full period |

## Verification
The hardest situations to reach are those where the clamps cut a window. One is a reference near the top, where the raised reference would pass the carrier peak. The other is a reference near the bottom, where the lowered reference would go below zero. In both cases, the two overlaps of a leg must still count as separate events on either side of the peak or the valley. The stimulus drives references at 150, 98 and 2 with a large displacement, and compares every cycle against a behavioural model. A second hard case is a change of inputs in mid-period. The bench changes references and displacement while the carrier is inside a window and confirms that the window still follows the old values.

// File: rtl/dsm_pkg.sv
`timescale 1ns/1ps
// Package: constants shared by the displaced-reference modulator blocks.
// Assumes a three-leg bridge; event counter sized for at most six events.
package dsm_pkg;
    localparam int NUM_LEGS = 3;
    localparam int EVT_W    = 3;
    localparam int MAX_EVTS = 2 * NUM_LEGS;

    typedef enum logic {
        DIR_UP   = 1'b1,
        DIR_DOWN = 1'b0
    } car_dir_e;
endpackage

// File: rtl/dsm_carrier.sv
`timescale 1ns/1ps
// Triangular carrier: counts 0 up to CAR_MAX and back down to 0.
// Assumes CAR_MAX >= 2 and fits in CAR_W bits. Flags the valley cycle.
module dsm_carrier #(
    parameter int CAR_W   = 8,
    parameter int CAR_MAX = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CAR_W-1:0] count,
    output logic             valley
);
    import dsm_pkg::*;

    localparam logic [CAR_W-1:0] TOP = CAR_W'(CAR_MAX);
    localparam logic [CAR_W-1:0] ONE = CAR_W'(1);

    car_dir_e dir_q;

    // Step the count and turn at the peak and at the valley.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            dir_q <= DIR_UP;
        end else if (dir_q == DIR_UP) begin
            count <= count + ONE;
            if (count + ONE == TOP) dir_q <= DIR_DOWN;
        end else begin
            count <= count - ONE;
            if (count - ONE == '0) dir_q <= DIR_UP;
        end
    end

    // Valley marker for reference capture and period accounting.
    always_comb valley = (count == '0);
endmodule

// File: rtl/dsm_leg.sv
`timescale 1ns/1ps
// One bridge leg: latches its phase reference at the valley, forms the
// raised and lowered references (clamped to 0..CAR_MAX), compares them
// with the carrier, and flags and edge-detects the gate overlap.
// Assumes the half displacement arrives already latched and signed.
module dsm_leg #(
    parameter int CAR_W   = 8,
    parameter int CAR_MAX = 100,
    parameter int DISP_W  = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [CAR_W-1:0]         ref_in,
    input  logic signed [DISP_W-1:0] half_disp,
    input  logic [CAR_W-1:0]         carrier,
    output logic                     gate_hi,
    output logic                     gate_lo,
    output logic                     overlap,
    output logic                     rise
);
    localparam int SW = ((CAR_W > DISP_W) ? CAR_W : DISP_W) + 2;
    localparam logic [CAR_W-1:0]  TOP   = CAR_W'(CAR_MAX);
    localparam logic signed [SW-1:0] TOP_S = SW'(CAR_MAX);

    logic [CAR_W-1:0]     ref_q;
    logic                 ov_prev_q;
    logic signed [SW-1:0] ref_s, half_s, hi_s, lo_s;
    logic [CAR_W-1:0]     hi_ref, lo_ref;

    // Capture the clamped phase reference only at the valley.
    always_ff @(posedge clk) begin
        if (!rst_n)    ref_q <= '0;
        else if (load) ref_q <= (ref_in > TOP) ? TOP : ref_in;
    end

    // Widen reference and half displacement to a common signed width.
    always_comb begin
        ref_s  = $signed({{(SW-CAR_W){1'b0}}, ref_q});
        half_s = SW'(half_disp);
        hi_s   = ref_s + half_s;
        lo_s   = ref_s - half_s;
    end

    // Clamp the raised reference into the carrier range.
    always_comb begin
        if (hi_s < 0)          hi_ref = '0;
        else if (hi_s > TOP_S) hi_ref = TOP;
        else                   hi_ref = hi_s[CAR_W-1:0];
    end

    // Clamp the lowered reference into the carrier range.
    always_comb begin
        if (lo_s < 0)          lo_ref = '0;
        else if (lo_s > TOP_S) lo_ref = TOP;
        else                   lo_ref = lo_s[CAR_W-1:0];
    end

    // Compare both references against the carrier.
    always_comb begin
        gate_hi = (hi_ref > carrier);
        gate_lo = (lo_ref < carrier);
        overlap = gate_hi & gate_lo;
        rise    = overlap & ~ov_prev_q;
    end

    // Remember last cycle's overlap for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ov_prev_q <= 1'b0;
        else        ov_prev_q <= overlap;
    end
endmodule

// File: rtl/dsm_event_count.sv
`timescale 1ns/1ps
// Counts overlap rising edges over all legs within one carrier period and
// presents the total of the finished period from the cycle after a valley.
// Assumes no overlap can rise in the valley cycle itself.
module dsm_event_count #(
    parameter int LEGS  = 3,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valley,
    input  logic [LEGS-1:0]  rises,
    output logic [CNT_W-1:0] total
);
    logic [CNT_W-1:0] acc_q;

    // Accumulate during the period; hand over and clear at the valley.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            total <= '0;
        end else if (valley) begin
            total <= acc_q;
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + CNT_W'($countones(rises));
        end
    end
endmodule

// File: rtl/displaced_st_modulator.sv
`timescale 1ns/1ps
// Displaced-reference shoot-through modulator, top level.
// Drives each leg's upper and lower switch from references offset by a
// signed displacement so that their pulses overlap at every commutation.
// Assumes references and displacement are steady sources; they are only
// sampled at the carrier valley.
module displaced_st_modulator #(
    parameter int CAR_W   = 8,
    parameter int CAR_MAX = 100,
    parameter int DISP_W  = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CAR_W-1:0]         ref_u,
    input  logic [CAR_W-1:0]         ref_v,
    input  logic [CAR_W-1:0]         ref_w,
    input  logic signed [DISP_W-1:0] disp,
    output logic [CAR_W-1:0]         carrier,
    output logic [2:0]               gate_hi,
    output logic [2:0]               gate_lo,
    output logic [2:0]               overlap,
    output logic [2:0]               event_count
);
    import dsm_pkg::*;

    logic                     valley;
    logic signed [DISP_W-1:0] disp_q;
    logic signed [DISP_W-1:0] half_disp;
    logic [CAR_W-1:0]         refs [NUM_LEGS];
    logic [NUM_LEGS-1:0]      rises;

    dsm_carrier #(.CAR_W(CAR_W), .CAR_MAX(CAR_MAX)) i_carrier (
        .clk(clk), .rst_n(rst_n), .count(carrier), .valley(valley)
    );

    // Capture the displacement only at the valley.
    always_ff @(posedge clk) begin
        if (!rst_n)      disp_q <= '0;
        else if (valley) disp_q <= disp;
    end

    // Half displacement, rounded toward minus infinity.
    always_comb half_disp = disp_q >>> 1;

    // Gather the phase references for the leg array.
    always_comb begin
        refs[0] = ref_u;
        refs[1] = ref_v;
        refs[2] = ref_w;
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        dsm_leg #(.CAR_W(CAR_W), .CAR_MAX(CAR_MAX), .DISP_W(DISP_W)) i_leg (
            .clk(clk), .rst_n(rst_n), .load(valley), .ref_in(refs[g]),
            .half_disp(half_disp), .carrier(carrier),
            .gate_hi(gate_hi[g]), .gate_lo(gate_lo[g]),
            .overlap(overlap[g]), .rise(rises[g])
        );
    end

    dsm_event_count #(.LEGS(NUM_LEGS), .CNT_W(EVT_W)) i_events (
        .clk(clk), .rst_n(rst_n), .valley(valley), .rises(rises),
        .total(event_count)
    );
endmodule

// File: rtl/dsm_checker.sv
`timescale 1ns/1ps
// Property checker for the displaced-reference modulator, bound to the top.
module dsm_checker #(
    parameter int CAR_W   = 8,
    parameter int CAR_MAX = 100,
    parameter int DISP_W  = 9
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [CAR_W-1:0]         carrier,
    input logic [2:0]               gate_hi,
    input logic [2:0]               gate_lo,
    input logic [2:0]               overlap,
    input logic [2:0]               event_count,
    input logic signed [DISP_W-1:0] disp_q
);
    logic armed;

    // Arm the step check one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_carrier_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((carrier == $past(carrier) + 1'b1) || ($past(carrier) == carrier + 1'b1)));

    p_peak_hi_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier == CAR_W'(CAR_MAX)) |-> (gate_hi == 3'b000));

    p_valley_lo_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier == '0) |-> (gate_lo == 3'b000 && overlap == 3'b000));

    p_no_ov_nonpos_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_q <= 0) |-> (overlap == 3'b000));

    p_count_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        event_count <= 3'd6);

    p_disp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier != '0) |=> $stable(disp_q));
endmodule

bind displaced_st_modulator dsm_checker #(
    .CAR_W(CAR_W), .CAR_MAX(CAR_MAX), .DISP_W(DISP_W)
) i_dsm_checker (
    .clk(clk), .rst_n(rst_n), .carrier(carrier), .gate_hi(gate_hi),
    .gate_lo(gate_lo), .overlap(overlap), .event_count(event_count),
    .disp_q(disp_q)
);

// File: tb/test_displaced_st_modulator.sv
`timescale 1ns/1ps
// Bench: behavioural model compared every cycle, plus directed checks.
module test_displaced_st_modulator;
    localparam int CW = 8;
    localparam int CMAX = 100;
    localparam int DW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] ref_u = '0, ref_v = '0, ref_w = '0;
    logic signed [DW-1:0] disp = '0;
    logic [CW-1:0] carrier;
    logic [2:0] gate_hi, gate_lo, overlap, event_count;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    displaced_st_modulator #(.CAR_W(CW), .CAR_MAX(CMAX), .DISP_W(DW)) i_displaced_st_modulator (
        .clk(clk), .rst_n(rst_n), .ref_u(ref_u), .ref_v(ref_v), .ref_w(ref_w),
        .disp(disp), .carrier(carrier), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .overlap(overlap), .event_count(event_count)
    );

    always #2.5 clk = ~clk;

    // Model state
    int m_c = 0, m_up = 1, m_d = 0, m_acc = 0, m_cnt = 0;
    int m_r[3] = '{0, 0, 0};
    bit [2:0] m_prev = '0;

    function automatic int clampi(int v);
        if (v < 0) return 0;
        if (v > CMAX) return CMAX;
        return v;
    endfunction

    function automatic int half_of(int d);
        if (d >= 0) return d / 2;
        return -((-d + 1) / 2);
    endfunction

    function automatic bit [2:0] m_ghi();
        bit [2:0] g;
        for (int i = 0; i < 3; i++) g[i] = (clampi(clampi(m_r[i]) + half_of(m_d)) > m_c);
        return g;
    endfunction

    function automatic bit [2:0] m_glo();
        bit [2:0] g;
        for (int i = 0; i < 3; i++) g[i] = (clampi(clampi(m_r[i]) - half_of(m_d)) < m_c);
        return g;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Advance the reference model at each active edge.
    always @(posedge clk) begin
        bit [2:0] fl;
        if (!rst_n) begin
            m_c = 0; m_up = 1; m_d = 0; m_acc = 0; m_cnt = 0; m_prev = '0;
            for (int i = 0; i < 3; i++) m_r[i] = 0;
        end else begin
            fl = m_ghi() & m_glo();
            if (m_c == 0) begin
                m_cnt = m_acc; m_acc = 0;
                m_r[0] = int'(ref_u); m_r[1] = int'(ref_v); m_r[2] = int'(ref_w);
                m_d = int'(disp);
            end else begin
                m_acc += $countones(fl & ~m_prev);
            end
            m_prev = fl;
            if (m_up == 1) begin m_c++; if (m_c == CMAX) m_up = 0; end
            else begin m_c--; if (m_c == 0) m_up = 1; end
        end
    end

    // Compare the outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 carrier", int'(carrier), m_c);
            chk("R3 upper gates", int'(gate_hi), int'(m_ghi()));
            chk("R4 lower gates", int'(gate_lo), int'(m_glo()));
            chk("R6 overlap", int'(overlap), int'(m_ghi() & m_glo()));
            chk("R8 event count", int'(event_count), m_cnt);
        end
    end

    task automatic wait_valley();
        @(negedge clk);
        while (carrier != '0) @(negedge clk);
    endtask

    // Apply inputs, let one full period run on them, check the count.
    task automatic run_period(int ru, int rv, int rw, int d, int exp, string req);
        ref_u = CW'(ru); ref_v = CW'(rv); ref_w = CW'(rw); disp = DW'(d);
        wait_valley();
        wait_valley();
        @(negedge clk);
        chk(req, int'(event_count), exp);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 carrier in reset", int'(carrier), 0);
        chk("R1 gates in reset", int'({gate_hi, gate_lo, overlap}), 0);
        chk("R1 count in reset", int'(event_count), 0);
        rst_n = 1'b1;
        run_period(30, 50, 70, 0, 0, "R10 zero disp");
        // R9: interior references, positive displacement
        run_period(30, 50, 70, 10, 6, "R9 six events");
        // R7: change inputs mid-period, old window must stay
        while (!(carrier == CW'(50))) @(negedge clk);
        ref_u = 0; ref_v = 0; ref_w = 0; disp = -20;
        while (!(carrier == CW'(66))) @(negedge clk);
        chk("R7 old window kept", int'(overlap), 3'b100);
        run_period(0, 0, 0, -20, 0, "R10 negative disp");
        // R5: clamps at top and bottom, wide displacement
        run_period(150, 98, 2, 20, 6, "R5 clamped windows");
        // R5: odd displacements round toward minus infinity
        run_period(40, 60, 80, 7, 6, "R5 odd positive disp");
        run_period(40, 60, 80, -7, 0, "R10 odd negative disp");
        // R9 boundaries
        run_period(40, 60, 80, 1, 0, "R9 disp one");
        run_period(40, 60, 80, 2, 6, "R9 disp two");
        run_period(10, 90, 50, 30, 6, "R9 spread refs");
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule